// File: doc/BRIEF.md
# PHY Control-Port Access Sequencer

This block performs single 16-bit register reads and writes on the control port of a serial link PHY. A host presents a request: a start pulse, a direction bit, a register address and, for writes, the data. The block then runs the access as a fixed series of strobe exchanges on a 20-bit control word. When the access ends it returns a one-cycle completion pulse, the read result and an error flag.

Each exchange follows a four-phase rule. The block raises one strobe and waits for the PHY acknowledge to go high. It then drops the strobe and waits for the acknowledge to go low. The acknowledge is first passed through a two-flop synchronizer. Every wait polls the acknowledge at a fixed spacing and gives up after a bounded number of polls. A give-up clears all strobes and ends the request with the error flag set.

A write to the clock-reset register at 0x7F3F with nonzero data is handled as a special case. After the data capture the PHY resets itself and can no longer acknowledge, so the block raises the write strobe and finishes without waiting.

Top module: `phy_ctl_seq`

## Requirements
- R1: The control word `phy_ctl_o` has these fields:
  - bit 19: read strobe;
  - bit 18: write strobe;
  - bit 17: data-capture strobe;
  - bit 16: address-capture strobe;
  - bits 15:0: the data-in field.

  At most one strobe is high at any time.
- R2: Each exchange works as follows:
  - A strobe is raised only while the synchronized acknowledge is low.
  - The strobe is held until the acknowledge reads high, then lowered.
  - The next step waits until the acknowledge reads low.
  - The data-in field does not change while a strobe is high.
- R3: A write works as follows:
  - The block waits DELAY_CYC cycles after start.
  - It runs an address-capture exchange with the address on data-in.
  - It runs a data-capture exchange with the write data on data-in.
  - It runs a write-strobe exchange.
- R4: A read runs the same settle delay and address-capture exchange, then a read-strobe exchange. `phy_dout_i` is sampled while the acknowledge is high. That value appears on `req_rdata_o` with the completion pulse. `req_rdata_o` changes at no other time.
- R5: A write to address 0x7F3F with nonzero data works as follows:
  - After the data-capture exchange, the control word becomes the write strobe plus the data.
  - Done is pulsed with no error and no acknowledge wait.
  - The word is held until the next start.
  - A write of zero data to 0x7F3F follows the normal write sequence.
- R6: Each acknowledge wait polls at most MAX_POLLS times, DELAY_CYC cycles apart. When the polls run out:
  - all strobes return to zero;
  - done pulses with `req_err_o` high;
  - the block goes idle.
- R7: A start is accepted only while `busy_o` is low, and start pulses while busy are ignored. `busy_o` is high from the cycle after an accepted start until the completion pulse.
- R8: `req_done_o` lasts one cycle and is never high while busy. `req_err_o` is low after a successful access and high after a timeout, and it holds until the next accepted start.
- R9: During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_start_i | input | 1 | Request start pulse |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | PHY register address |
| req_wdata_i | input | 16 | Write data |
| req_done_o | output | 1 | One-cycle completion pulse |
| req_rdata_o | output | 16 | Read result |
| req_err_o | output | 1 | Acknowledge timeout flag |
| busy_o | output | 1 | Request in progress |
| phy_ctl_o | output | 20 | Strobes (19:16) and data-in (15:0) |
| phy_ack_i | input | 1 | PHY acknowledge, asynchronous |
| phy_dout_i | input | 16 | PHY data-out field |

## Verification
Several properties are checked on every cycle:
- strobe exclusivity;
- strobes rising only against a low synchronized acknowledge;
- data-in held steady under an active strobe;
- the single-cycle done pulse and the cleared strobes on an error completion;
- busy rising only after a start;
- the poll counter and the delay counter staying in range.

Other behaviour can only be seen through the bench's scenarios. That covers the phase order and the field values seen by a PHY responder with random acknowledge latency, and the settle spacing and exact timeout length in cycles. It also covers the read result, the clock-reset shortcut, and the dropping of starts that arrive while busy.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

  localparam int unsigned STB_N = 4;

  // strobe nibble, bit 0 maps to control bit 16
  localparam logic [STB_N-1:0] STB_CA = 4'b0001;
  localparam logic [STB_N-1:0] STB_CD = 4'b0010;
  localparam logic [STB_N-1:0] STB_WR = 4'b0100;
  localparam logic [STB_N-1:0] STB_RD = 4'b1000;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETTLE,
    S_LOAD,
    S_WAIT_HI,
    S_WAIT_LO
  } seq_st_e;

  typedef enum logic [1:0] {
    P_ADDR,
    P_DATA,
    P_WSTB,
    P_RSTB
  } phase_e;

  function automatic logic [STB_N-1:0] stb_of(phase_e p);
    case (p)
      P_ADDR:  return STB_CA;
      P_DATA:  return STB_CD;
      P_WSTB:  return STB_WR;
      default: return STB_RD;
    endcase
  endfunction

endpackage

// File: rtl/phy_ctl_sync2.sv
module phy_ctl_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[0], d_i};
  end

  assign q_o = ff_q[1];
endmodule

// File: rtl/phy_ctl_timer.sv
module phy_ctl_timer #(
  parameter int unsigned CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic zero_o
);
  localparam int unsigned W = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [W-1:0] RELOAD = W'(CYC - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= RELOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  assert_delay_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RELOAD);
  assert_delay_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == RELOAD));
endmodule

// File: rtl/phy_ctl_polls.sv
module phy_ctl_polls #(
  parameter int unsigned LIMIT = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == TOP);

  assert_poll_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP);
endmodule

// File: rtl/phy_ctl_seq.sv
module phy_ctl_seq
  import phy_ctl_pkg::*;
#(
  parameter int unsigned          FIELD_W   = 16,
  parameter int unsigned          DELAY_CYC = 5000,
  parameter int unsigned          MAX_POLLS = 5000,
  parameter logic [FIELD_W-1:0]   RST_ADDR  = FIELD_W'(16'h7F3F)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_start_i,
  input  logic                     req_write_i,
  input  logic [FIELD_W-1:0]       req_addr_i,
  input  logic [FIELD_W-1:0]       req_wdata_i,
  output logic                     req_done_o,
  output logic [FIELD_W-1:0]       req_rdata_o,
  output logic                     req_err_o,
  output logic                     busy_o,
  output logic [FIELD_W+STB_N-1:0] phy_ctl_o,
  input  logic                     phy_ack_i,
  input  logic [FIELD_W-1:0]       phy_dout_i
);
  seq_st_e              st_q;
  phase_e               ph_q;
  logic [STB_N-1:0]     stb_q;
  logic [FIELD_W-1:0]   din_q, addr_q, wdata_q, rbuf_q, rdata_q;
  logic                 wr_q, done_q, err_q;

  logic ack_s, tmr_zero, tmr_load, poll_last, poll_inc, poll_clr;
  logic waiting, poll, hit, miss, expired, accept, kick;

  phy_ctl_sync2 u_ack_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(phy_ack_i), .q_o(ack_s)
  );

  phy_ctl_timer #(.CYC(DELAY_CYC)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .zero_o(tmr_zero)
  );

  phy_ctl_polls #(.LIMIT(MAX_POLLS)) u_polls (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(poll_clr), .inc_i(poll_inc),
    .last_o(poll_last)
  );

  always_comb begin
    waiting  = (st_q == S_WAIT_HI) || (st_q == S_WAIT_LO);
    poll     = waiting && tmr_zero;
    hit      = poll && (ack_s == (st_q == S_WAIT_HI));
    miss     = poll && !hit;
    expired  = miss && poll_last;
    accept   = (st_q == S_IDLE) && req_start_i;
    poll_inc = miss && !poll_last;
    tmr_load = accept || poll_inc;
    poll_clr = accept || hit;
    kick     = (addr_q == RST_ADDR) && (wdata_q != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      ph_q    <= P_ADDR;
      stb_q   <= '0;
      din_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rbuf_q  <= '0;
      rdata_q <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_start_i) begin
          st_q    <= S_SETTLE;
          ph_q    <= P_ADDR;
          stb_q   <= '0;
          wr_q    <= req_write_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          err_q   <= 1'b0;
        end
        S_SETTLE: if (tmr_zero) begin
          st_q  <= S_LOAD;
          din_q <= addr_q;
        end
        S_LOAD: begin
          st_q  <= S_WAIT_HI;
          stb_q <= stb_of(ph_q);
        end
        S_WAIT_HI: begin
          if (expired) begin
            stb_q  <= '0;
            st_q   <= S_IDLE;
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else if (hit) begin
            if (ph_q == P_RSTB) rbuf_q <= phy_dout_i;
            stb_q <= '0;
            st_q  <= S_WAIT_LO;
          end
        end
        S_WAIT_LO: begin
          if (expired) begin
            stb_q  <= '0;
            st_q   <= S_IDLE;
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else if (hit) begin
            unique case (ph_q)
              P_ADDR: begin
                st_q <= S_LOAD;
                if (wr_q) begin
                  ph_q  <= P_DATA;
                  din_q <= wdata_q;
                end else begin
                  ph_q  <= P_RSTB;
                end
              end
              P_DATA: begin
                if (kick) begin
                  // PHY resets itself here and cannot acknowledge
                  stb_q  <= STB_WR;
                  din_q  <= wdata_q;
                  st_q   <= S_IDLE;
                  done_q <= 1'b1;
                end else begin
                  ph_q <= P_WSTB;
                  st_q <= S_LOAD;
                end
              end
              P_WSTB: begin
                st_q   <= S_IDLE;
                done_q <= 1'b1;
              end
              default: begin
                st_q    <= S_IDLE;
                done_q  <= 1'b1;
                rdata_q <= rbuf_q;
              end
            endcase
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign req_done_o  = done_q;
  assign req_err_o   = err_q;
  assign req_rdata_o = rdata_q;
  assign phy_ctl_o   = {stb_q, din_q};

  assert_one_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(phy_ctl_o[FIELD_W+STB_N-1:FIELD_W]));
  assert_raise_on_low_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|phy_ctl_o[FIELD_W+STB_N-1:FIELD_W]) |-> !ack_s);
  assert_din_steady_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|phy_ctl_o[FIELD_W+STB_N-1:FIELD_W]) && $past(|phy_ctl_o[FIELD_W+STB_N-1:FIELD_W]))
      |-> $stable(phy_ctl_o[FIELD_W-1:0]));
  assert_rdata_on_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(req_rdata_o) |-> req_done_o);
  assert_abort_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_done_o && req_err_o) |-> (phy_ctl_o[FIELD_W+STB_N-1:FIELD_W] == '0));
  assert_busy_from_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_start_i));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |=> !req_done_o);
  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |-> !busy_o);
endmodule

// File: tb/phy_ctl_seq_tb_top.sv
module phy_ctl_seq_tb_top;
  localparam int unsigned DLY   = 4;
  localparam int unsigned POLLS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic done, err, busy;
  logic [15:0] rdata;
  logic [19:0] ctl;
  logic ack = 1'b0;
  logic [15:0] dout = '0;

  int checks = 0, errs = 0;

  always #10 clk = ~clk;

  phy_ctl_seq #(.DELAY_CYC(DLY), .MAX_POLLS(POLLS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_start_i(start), .req_write_i(wr),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_done_o(done),
    .req_rdata_o(rdata), .req_err_o(err), .busy_o(busy), .phy_ctl_o(ctl),
    .phy_ack_i(ack), .phy_dout_i(dout)
  );

  // PHY responder: 0 normal, 1 never ack, 2 ack never drops
  int mode = 0;
  bit ignore_wr = 1'b0;
  int lat = 0;
  int cyc_n = 0;
  logic [3:0] prev_stb = '0;
  logic [15:0] cap_addr = '0;
  int log_n = 0;
  logic [3:0]  log_stb [16];
  logic [15:0] log_din [16];
  int          log_cyc [16];
  wire  [3:0] rs = ctl[19:16];

  function automatic logic [15:0] reg_val(logic [15:0] a);
    return a ^ 16'h5AC3;
  endfunction

  always @(posedge clk) begin
    cyc_n <= cyc_n + 1;
    if (rst_n) begin
      if (prev_stb == 4'b0 && rs != 4'b0) begin
        if (log_n < 16) begin
          log_stb[log_n] = rs;
          log_din[log_n] = ctl[15:0];
          log_cyc[log_n] = cyc_n;
          log_n++;
        end
        if (rs == 4'b0001) cap_addr = ctl[15:0];
      end
      prev_stb <= rs;
      if (rs != 4'b0 && !ack && mode != 1 && !(ignore_wr && rs == 4'b0100)) begin
        if (lat == 0) begin
          ack  <= 1'b1;
          dout <= reg_val(cap_addr);
          lat  <= $urandom_range(0, 5);
        end else lat <= lat - 1;
      end else if (rs == 4'b0 && ack && mode != 2) begin
        if (lat == 0) begin
          ack <= 1'b0;
          lat <= $urandom_range(0, 5);
        end else lat <= lat - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  int last_cyc;
  int start_cyc;

  task automatic access(input bit w, input logic [15:0] a, input logic [15:0] d);
    log_n = 0;
    @(negedge clk);
    start = 1'b1; wr = w; addr = a; wdata = d;
    start_cyc = cyc_n;
    @(negedge clk);
    start = 1'b0;
    last_cyc = 0;
    while (!done && last_cyc < 3000) begin
      @(negedge clk);
      last_cyc++;
    end
  endtask

  task automatic settle_bus();
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(done == 0 && err == 0 && busy == 0, "R9", "reset flags", {done, err, busy}, 0);
    chk(ctl == 20'h0 && rdata == 16'h0, "R9", "reset ctl", ctl, 0);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [15:0] d);
    access(1'b1, a, d);
    chk(done && !err, "R3", "write completes", {done, err}, 2'b10);
    @(negedge clk);
    chk(!done && !busy, "R8", "done one cycle", {done, busy}, 0);
    chk(log_n == 3, "R3", "write step count", log_n, 3);
    chk(log_stb[0] == 4'b0001 && log_din[0] == a, "R3", "addr capture",
        {log_stb[0], log_din[0]}, {4'b0001, a});
    chk(log_stb[1] == 4'b0010 && log_din[1] == d, "R3", "data capture",
        {log_stb[1], log_din[1]}, {4'b0010, d});
    chk(log_stb[2] == 4'b0100, "R1", "write strobe bit 18", log_stb[2], 4'b0100);
    chk(log_cyc[0] - start_cyc >= int'(DLY), "R3", "settle delay",
        log_cyc[0] - start_cyc, DLY);
    chk(ctl[19:16] == 4'b0, "R2", "strobes low after write", ctl, 0);
  endtask

  task automatic t_read(input logic [15:0] a);
    access(1'b0, a, 16'h0);
    chk(done && !err, "R4", "read completes", {done, err}, 2'b10);
    chk(rdata == reg_val(a), "R4", "read data", rdata, reg_val(a));
    chk(log_n == 2 && log_stb[0] == 4'b0001 && log_din[0] == a, "R4", "read addr phase",
        {log_stb[0], log_din[0]}, {4'b0001, a});
    chk(log_stb[1] == 4'b1000, "R1", "read strobe bit 19", log_stb[1], 4'b1000);
    settle_bus();
  endtask

  task automatic t_patterns();
    for (int i = 0; i < 6; i++) begin
      logic [15:0] a = 16'($urandom_range(0, 16'h7000));
      logic [15:0] d = 16'($urandom);
      if (i % 2 == 0) t_write(a, d);
      else            t_read(a);
      settle_bus();
    end
  endtask

  task automatic t_clk_reset();
    ignore_wr = 1'b1;
    access(1'b1, 16'h7F3F, 16'h0001);
    chk(done && !err, "R5", "reset write no ack wait", {done, err}, 2'b10);
    chk(ctl == {4'b0100, 16'h0001}, "R5", "reset word held", ctl, {4'b0100, 16'h0001});
    repeat (10) @(negedge clk);
    chk(ctl == {4'b0100, 16'h0001} && !busy, "R5", "word held idle", ctl,
        {4'b0100, 16'h0001});
    access(1'b1, 16'h7F3F, 16'h0000);
    chk(done && err, "R5", "zero data waits write ack", {done, err}, 2'b11);
    chk(log_n == 3, "R5", "zero data full sequence", log_n, 3);
    chk(ctl[19:16] == 4'b0, "R6", "strobes cleared on abort", ctl, 0);
    ignore_wr = 1'b0;
    settle_bus();
  endtask

  task automatic t_timeout_hi();
    mode = 1;
    access(1'b0, 16'h0123, 16'h0);
    chk(done && err, "R6", "no ack timeout", {done, err}, 2'b11);
    chk(last_cyc >= 32 && last_cyc <= 36, "R6", "timeout length", last_cyc, 34);
    chk(ctl == 20'h0 || ctl[19:16] == 4'b0, "R6", "strobes zero", ctl, 0);
    @(negedge clk);
    chk(err && !busy, "R8", "err held", {err, busy}, 2'b10);
    mode = 0;
    settle_bus();
  endtask

  task automatic t_timeout_lo();
    mode = 2;
    access(1'b1, 16'h0456, 16'hBEEF);
    chk(done && err && log_n == 1, "R6", "ack stuck high timeout", {done, err, log_n[3:0]},
        {2'b11, 4'd1});
    mode = 0;
    settle_bus();
    chk(ack == 1'b0, "R2", "responder released", ack, 0);
  endtask

  task automatic t_busy_ignore();
    int extra;
    log_n = 0;
    @(negedge clk);
    start = 1'b1; wr = 1'b0; addr = 16'h0A0A;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk(busy, "R7", "busy during access", busy, 1);
    start = 1'b1; wr = 1'b1; addr = 16'h0B0B; wdata = 16'h1111;
    @(negedge clk);
    start = 1'b0;
    last_cyc = 0;
    while (!done && last_cyc < 3000) begin
      @(negedge clk);
      last_cyc++;
    end
    chk(done && rdata == reg_val(16'h0A0A), "R7", "first request kept", rdata,
        reg_val(16'h0A0A));
    extra = 0;
    repeat (40) begin
      @(negedge clk);
      if (busy || done) extra++;
    end
    chk(extra == 0 && log_n == 2, "R7", "second start ignored", log_n, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_write(16'h1234, 16'hA55A);
    settle_bus();
    t_read(16'h2003);
    t_patterns();
    t_clk_reset();
    t_timeout_hi();
    t_timeout_lo();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule